// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block sits between a simple synchronous host port and an asynchronous DRAM whose row and column addresses share one set of address pins. The host presents a word address, a direction flag and write data with a valid strobe while the controller shows ready. The controller splits the address into a row half and a column half. It opens the row with a row strobe and then moves the word with a column strobe. Read data comes back with a one-cycle done pulse, and a write also ends with a done pulse.

The controller keeps a row open after an access. When the next access targets the same row, it issues only a new column cycle. A row change closes the row, waits the precharge time and opens the new row. A refresh timer raises a pending request at a fixed interval. That request takes priority at the next access boundary and stalls the host. Each refresh is a row-strobe-only cycle on the row named by a wrapping refresh counter. After reset the controller waits a settle time, then refreshes every row once before it first reports ready.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The host address splits into a row (bits 21:11) and a column (bits 10:0). The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_cas_n` is low only while `dram_ras_n` is low, and each access opens its row before its column strobe.
- R3: An access to the row left open by the previous access, with no refresh in between, causes no `dram_ras_n` falling edge. It uses only a new column strobe.
- R4: `dram_ras_n` stays high for at least T_RP clocks before every falling edge. This includes closing one row before opening another.
- R5: While the host is idle, one refresh (a `dram_ras_n` low period with no column strobe) happens every REF_INTERVAL clocks. The refresh row starts at 0 after reset, rises by 1 per refresh and wraps after the last row.
- R6: `req_ready` is low while a refresh or a row opening is under way, so a pending refresh stalls host requests.
- R7: For a write, `dram_we_n` is low and `dram_dq` carries known data in the cycle before `dram_cas_n` falls. `dram_dq` is high impedance whenever `dram_we_n` is high and no read column strobe is active.
- R8: `rsp_done` is a single-cycle pulse at the end of each access. For a read, `rsp_rdata` holds the word most recently written to that address, or 0 if the address has never been written.
- R9: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. Changes to the request inputs after that cycle do not affect the access under way.
- R10: Out of reset, `dram_ras_n` and `dram_cas_n` are high, `req_ready` is low and `dram_dq` is released. The first `dram_ras_n` fall comes no earlier than T_SETTLE clocks after reset. `req_ready` first rises only after all 2048 rows have been refreshed in order.
- R11: Between the `dram_ras_n` fall that opens a row and the first `dram_cas_n` fall in that row, at least T_RCD+1 clocks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper half |
| req_wdata | input | 4 | Write data |
| rsp_done | output | 1 | One-cycle pulse at the end of an access |
| rsp_rdata | output | 4 | Read data, valid with rsp_done |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | 4 | Bidirectional data |

## Verification
The assertions assume the host holds `req_valid` for no more than one cycle of acceptance and does not depend on request inputs after the handshake. They also assume the memory drives `dram_dq` only while a read column strobe is low. The bench's memory model follows that rule. The host tasks raise the strobe only at a cycle where ready is high, drop it after one edge, and then scramble address and data to exercise R9. Random addresses reuse the previous row half of the time, so page hits, row changes and interleaved refreshes all occur.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_ACT,
    ST_COL,
    ST_CAS,
    ST_OPEN
  } dram_st_e;
endpackage

// File: rtl/dram_wait_cnt.sv
module dram_wait_cnt #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= CNT_W'(RST_VAL);
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_WAIT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W        = 11,
  parameter int CNT_W        = 16,
  parameter int REF_INTERVAL = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row,
  output logic             row_last
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;
  localparam logic [CNT_W-1:0] DIV_MAX = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pend  <= 1'b0;
      row   <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      if (ack) row <= row + 1'b1;
    end
  end

  assign row_last = (row == ROW_MAX);

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend); // R5
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ack) |=> $stable(row)); // R5
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DQ_W         = 4,
  parameter int CNT_W        = 16,
  parameter int T_SETTLE     = 20,
  parameter int T_RP         = 2,
  parameter int T_RAS_REF    = 3,
  parameter int T_RCD        = 2,
  parameter int T_CL         = 2,
  parameter int REF_INTERVAL = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_done,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  inout  wire  [DQ_W-1:0]        dram_dq
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  dram_st_e st_q, st_d;

  logic [ROW_W-1:0] lat_row_q, lat_row_d, open_row_q;
  logic [COL_W-1:0] lat_col_q, lat_col_d;
  logic             lat_we_q, lat_we_d;
  logic [DQ_W-1:0]  lat_wd_q, lat_wd_d;
  logic             have_q, init_q;
  logic             accept, hit, expired, wait_load;
  logic [CNT_W-1:0] wait_val;
  logic             ref_pend, ref_ack, ref_last;
  logic [ROW_W-1:0] ref_row;
  logic [PIN_W-1:0] addr_d;
  logic             ras_n_d, cas_n_d, wr_d;
  logic             dq_oe_q;
  logic [DQ_W-1:0]  dq_out_q;
  logic             cas_end;

  dram_wait_cnt #(
    .CNT_W  (CNT_W),
    .RST_VAL(T_SETTLE - 1)
  ) u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_load),
    .load_val(wait_val),
    .expired (expired)
  );

  dram_refresh_sched #(
    .ROW_W       (ROW_W),
    .CNT_W       (CNT_W),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_ref (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pend    (ref_pend),
    .row     (ref_row),
    .row_last(ref_last)
  );

  assign req_ready = (st_q == ST_IDLE || st_q == ST_OPEN) && !ref_pend && !init_q;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr[ADDR_W-1:COL_W] == open_row_q);
  assign ref_ack   = (st_q == ST_REF) && expired;
  assign cas_end   = (st_q == ST_CAS) && expired;

  assign lat_row_d = accept ? req_addr[ADDR_W-1:COL_W] : lat_row_q;
  assign lat_col_d = accept ? req_addr[COL_W-1:0]      : lat_col_q;
  assign lat_we_d  = accept ? req_we                   : lat_we_q;
  assign lat_wd_d  = accept ? req_wdata                : lat_wd_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SETTLE: if (expired) st_d = ST_PRE;
      ST_PRE: begin
        if (expired) begin
          if (ref_pend || init_q) st_d = ST_REF;
          else if (have_q)        st_d = ST_ACT;
          else                    st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (ref_pend)    st_d = ST_REF;
        else if (accept) st_d = ST_ACT;
      end
      ST_OPEN: begin
        if (ref_pend)    st_d = ST_PRE;
        else if (accept) st_d = hit ? ST_COL : ST_PRE;
      end
      ST_REF:  if (expired) st_d = ST_PRE;
      ST_ACT:  if (expired) st_d = ST_COL;
      ST_COL:  st_d = ST_CAS;
      ST_CAS:  if (expired) st_d = ST_OPEN;
      default: st_d = ST_PRE;
    endcase
  end

  always_comb begin
    wait_load = (st_d != st_q);
    unique case (st_d)
      ST_PRE:  wait_val = CNT_W'(T_RP - 1);
      ST_REF:  wait_val = CNT_W'(T_RAS_REF - 1);
      ST_ACT:  wait_val = CNT_W'(T_RCD - 1);
      ST_CAS:  wait_val = CNT_W'(T_CL - 1);
      default: wait_val = '0;
    endcase
  end

  always_comb begin
    ras_n_d = !(st_d == ST_REF || st_d == ST_ACT || st_d == ST_COL ||
                st_d == ST_CAS || st_d == ST_OPEN);
    cas_n_d = (st_d != ST_CAS);
    wr_d    = (st_d == ST_COL || st_d == ST_CAS) && lat_we_d;
    unique case (st_d)
      ST_REF:        addr_d = PIN_W'(ref_row);
      ST_ACT:        addr_d = PIN_W'(lat_row_d);
      ST_COL, ST_CAS: addr_d = PIN_W'(lat_col_d);
      default:       addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_SETTLE;
      init_q     <= 1'b1;
      have_q     <= 1'b0;
      lat_row_q  <= '0;
      lat_col_q  <= '0;
      lat_we_q   <= 1'b0;
      lat_wd_q   <= '0;
      open_row_q <= '0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dq_oe_q    <= 1'b0;
      dq_out_q   <= '0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st_q      <= st_d;
      lat_row_q <= lat_row_d;
      lat_col_q <= lat_col_d;
      lat_we_q  <= lat_we_d;
      lat_wd_q  <= lat_wd_d;
      if (ref_ack && ref_last) init_q <= 1'b0;
      if (accept)       have_q <= 1'b1;
      else if (cas_end) have_q <= 1'b0;
      if (st_d == ST_ACT && st_q != ST_ACT) open_row_q <= lat_row_d;
      dram_addr  <= addr_d;
      dram_ras_n <= ras_n_d;
      dram_cas_n <= cas_n_d;
      dram_we_n  <= !wr_d;
      dq_oe_q    <= wr_d;
      dq_out_q   <= lat_wd_d;
      rsp_done   <= cas_end;
      if (cas_end && !lat_we_q) rsp_rdata <= dram_dq;
    end
  end

  assign dram_dq = dq_oe_q ? dq_out_q : 'z;

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n); // R2
  AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R7
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    dq_oe_q |-> !dram_we_n); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R8
  AST_READY_NO_CAS: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> dram_cas_n); // R6
  AST_INIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    init_q |-> !req_ready); // R10
  AST_ACCEPT_ONE: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R9
endmodule

// File: tb/dram_mux_ctrl_tb.sv
module dram_mux_ctrl_tb;
  localparam int ROW_W = 11;
  localparam int COL_W = 11;
  localparam int ROWS  = 1 << ROW_W;
  localparam int T_SETTLE = 20;
  localparam int T_RP  = 2;
  localparam int T_RCD = 2;
  localparam int REF_INTERVAL = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [3:0]  rsp_rdata;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n;
  wire  [3:0]  dram_dq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dram_mux_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq(dram_dq)
  );

  // memory model and pin monitor
  logic [3:0]  mem [int];
  logic [3:0]  ref_mem [int];
  logic [3:0]  rd_val = '0;
  logic [10:0] m_row = '0, m_col = '0;
  logic        prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, cas_seen = 1'b0;
  int cyc = 0, ras_low = 0, ras_high = 1000, first_fall = -1;
  int ras_falls = 0, ref_cnt = 0, ref_exp = 0;
  int v_rp = 0, v_seq = 0, v_rcd = 0, v_we = 0, v_dq = 0, v_ref = 0, v_rdy = 0;

  assign dram_dq = (!dram_cas_n && dram_we_n) ? rd_val : 4'bzzzz;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        ras_falls++;
        if (first_fall < 0) first_fall = cyc;
        if (ras_high < T_RP) v_rp++;
        m_row = dram_addr; cas_seen = 1'b0; ras_low = 0;
      end
      if (!dram_ras_n) ras_low++;
      if (prev_cas && !dram_cas_n) begin
        if (dram_ras_n) v_seq++;
        if (!cas_seen && ras_low < T_RCD + 2) v_rcd++;
        m_col = dram_addr;
        if (!dram_we_n) begin
          if (prev_we) v_we++;
          if ($isunknown(dram_dq)) v_we++;
          mem[int'({m_row, m_col})] = dram_dq;
        end else begin
          rd_val = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 4'h0;
        end
        cas_seen = 1'b1;
      end
      if (!prev_ras && dram_ras_n) begin
        if (!cas_seen) begin
          if (int'(m_row) != ref_exp) v_ref++;
          ref_exp = (ref_exp + 1) % ROWS;
          ref_cnt++;
        end
        ras_high = 0;
      end
      if (dram_ras_n) ras_high++;
      if (dram_we_n && dram_cas_n && dram_dq !== 4'bzzzz) v_dq++;
      if (req_ready && !dram_ras_n && !cas_seen) v_rdy++;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_read(input logic [21:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
  endfunction

  function automatic int exp_falls(input bit same_row, input int refs);
    return (same_row && refs == 0) ? 0 : refs + 1;
  endfunction

  initial begin
    #1200000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  int snap_falls = 0, snap_refs = 0;
  bit have_prev = 1'b0;
  logic [10:0] prev_row = '0;

  task automatic access(input bit we, input logic [21:0] a, input logic [3:0] wd,
                        output logic [3:0] rd);
    int falls, refs, guard;
    bit same;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 22'($urandom); req_wdata = 4'($urandom); req_we = ~we; // R9 scramble
    guard = 0;
    while (!rsp_done && guard < 200) begin @(negedge clk); guard++; end
    chk(rsp_done, "R8 done", int'(rsp_done), 1);
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R8 single pulse", int'(rsp_done), 0);
    falls = ras_falls - snap_falls;
    refs  = ref_cnt - snap_refs;
    same  = have_prev && (a[21:11] == prev_row);
    chk(falls == exp_falls(same, refs), same ? "R3 page hit" : "R4 row change",
        falls, exp_falls(same, refs));
    chk(m_row == a[21:11] && m_col == a[10:0], "R1 row/col split",
        int'({m_row, m_col}), int'(a));
    if (we) ref_mem[int'(a)] = wd;
    else chk(rd == exp_read(a), "R8 read data", int'(rd), int'(exp_read(a)));
    snap_falls = ras_falls; snap_refs = ref_cnt;
    prev_row = a[21:11]; have_prev = 1'b1;
  endtask

  initial begin
    logic [3:0] rd;
    logic [21:0] a;
    int r0, guard;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n, "R10 reset strobes", int'({dram_ras_n, dram_cas_n}), 3);
    chk(!req_ready, "R10 reset ready", int'(req_ready), 0);
    chk(dram_dq === 4'bzzzz, "R10 reset dq released", int'(dram_dq), 0);
    guard = 0;
    while (!req_ready && guard < 40000) begin @(negedge clk); guard++; end
    chk(req_ready, "R10 ready after init", int'(req_ready), 1);
    chk(ref_cnt >= ROWS, "R10 all rows refreshed", ref_cnt, ROWS);
    chk(first_fall >= T_SETTLE, "R10 settle wait", first_fall, T_SETTLE);
    chk(v_ref == 0, "R5 refresh order during init", v_ref, 0);
    snap_falls = ras_falls; snap_refs = ref_cnt;

    // directed: write, read back, page hit, row change
    access(1'b1, 22'h155AAA, 4'hA, rd);
    access(1'b0, 22'h155AAA, 4'h0, rd);
    access(1'b1, 22'h155001, 4'h5, rd);
    access(1'b0, 22'h155001, 4'h0, rd);
    access(1'b0, 22'h000001, 4'h0, rd);       // never written: expect 0
    access(1'b1, 22'h3FFFFF, 4'hF, rd);       // top row and column
    access(1'b0, 22'h3FFFFF, 4'h0, rd);
    access(1'b0, 22'h155AAA, 4'h0, rd);

    // idle refresh rate
    r0 = ref_cnt;
    repeat (10 * REF_INTERVAL) @(negedge clk);
    chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R5 idle refresh rate", ref_cnt - r0, 10);
    snap_falls = ras_falls; snap_refs = ref_cnt; have_prev = 1'b0;

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      a = 22'($urandom);
      if (have_prev && ($urandom % 2 == 0)) a[21:11] = prev_row;
      if ($urandom % 3 == 0 && ref_mem.num() > 0) a[10:0] = 11'($urandom % 8);
      access(($urandom % 2) == 1, a, 4'($urandom), rd);
    end

    chk(v_seq == 0, "R2 CAS only under RAS", v_seq, 0);
    chk(v_rp == 0, "R4 precharge time", v_rp, 0);
    chk(v_rcd == 0, "R11 RAS-to-CAS delay", v_rcd, 0);
    chk(v_we == 0, "R7 write setup", v_we, 0);
    chk(v_dq == 0, "R7 bus released", v_dq, 0);
    chk(v_ref == 0, "R5 refresh row order", v_ref, 0);
    chk(v_rdy == 0, "R6 no ready during row strobe", v_rdy, 0);
    report();
  end
endmodule